// File: doc/BRIEF.md
# Serial Output Pin Software Override

This block sits between a UART transmitter's serial data output and the transmit pin. Software can use it to take the pin level over directly, and it can read back the raw level of the receive pin. It holds two state bits. One is an override enable. The other is a software pin level. A registered multiplexer picks what the transmit pin carries: the UART shift-out data, the software level, or the idle level.

A register port accesses both bits. A write carries a per-bit mask, so the enable and the level can be changed on their own. Reads are combinational. A qualifier input marks a read as the read phase of a read-modify-write. Such a read returns the level the transmit pin is driving now, instead of the synchronized receive pin. Writing that value back therefore leaves the pin where it was. A level written while the override is off is stored, and it does not reach the pin. When the override is turned on later, the stored level appears on the pin at the next clock edge, with no detour through the UART data.

Top module: `sout_pin_override`

## Requirements
- R1: After reset the transmit pin is 1, the override enable is 0 (read data bit 1 = 0) and the stored software level is 1. Enabling the override with no level write then drives 1.
- R2: When the output enable was 1 at a clock edge and the override enable is 1 after it, the transmit pin equals the stored level from that edge on.
- R3: When the output enable is 0 at a clock edge, the transmit pin is 1 after that edge, whatever the override state and UART data.
- R4: When the output enable is 1 and the override enable is 0 at a clock edge, the transmit pin takes the UART serial-out value sampled at that edge.
- R5: A write with wmask bit 0 set loads wdata bit 0 as the level. A write with wmask bit 1 set loads wdata bit 1 as the enable. A level written while the enable is 0 leaves the pin on UART data, and it takes effect at the edge that sets the enable. With no write, both bits hold.
- R6: A normal read (rd=1, rmw=0) returns in bit 0 the receive pin after a two-flop synchronizer: a receive-pin change shows up after exactly two rising edges.
- R7: A read with rmw=1 returns in bit 0 the current transmit pin level, not the receive pin. Every read returns the override enable in bit 1.
- R8: When rd is 0, the read data is 0.
- R9: Writing back the value returned by a read-modify-write read leaves the transmit pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soe | input | 1 | Serial output enable from the UART mode setting |
| tx_data | input | 1 | UART shift-out data |
| sin | input | 1 | Raw receive pin level (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_wmask | input | 2 | Write mask: bit 1 enable, bit 0 level |
| reg_wdata | input | 2 | Write data: bit 1 enable, bit 0 level |
| reg_rd | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Read is the read phase of a read-modify-write |
| reg_rdata | output | 2 | Read data: bit 1 enable, bit 0 pin level |
| sout | output | 1 | Transmit pin level |

## Verification
A table of vectors drives the pin multiplexer through all three sources. UART data toggles under the override, telling pass-through apart from software drive. A level is written while the override is off, which shows the value is stored but not driven until the enable write. The output enable is dropped while the override holds 0, which shows the idle level wins. Directed steps then tell the two read kinds apart by holding the receive and transmit pins at opposite levels, count the synchronizer delay edge by edge, write a read-modify-write value back, and confirm the reset level of the stored bit by enabling with no level write.

// File: rtl/pinovr_pkg.sv
package pinovr_pkg;
    localparam int unsigned CTRL_W  = 2;
    localparam int unsigned EN_BIT  = 1;
    localparam int unsigned LVL_BIT = 0;

    typedef struct packed {
        logic en;
        logic lvl;
        logic sout;
    } ovr_state_t;
endpackage

// File: rtl/pinovr_sync.sv
module pinovr_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = din;
        end else begin : g_many
            assign chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pinovr_ctrl.sv
module pinovr_ctrl
    import pinovr_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1,
    parameter logic RST_LEVEL  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soe,
    input  logic              tx_data,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wmask,
    input  logic [CTRL_W-1:0] wdata,
    output logic              en,
    output logic              lvl,
    output logic              sout
);
    ovr_state_t st_d, st_q;

    // Next state: register bits first, then the pin from the new bits so an
    // enable write switches the pin on the same edge.
    always_comb begin
        st_d = st_q;
        if (wr && wmask[EN_BIT])  st_d.en  = wdata[EN_BIT];
        if (wr && wmask[LVL_BIT]) st_d.lvl = wdata[LVL_BIT];
        if (!soe)         st_d.sout = IDLE_LEVEL;
        else if (st_d.en) st_d.sout = st_d.lvl;
        else              st_d.sout = tx_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= 1'b0;
            st_q.lvl  <= RST_LEVEL;
            st_q.sout <= IDLE_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign lvl  = st_q.lvl;
    assign sout = st_q.sout;
endmodule

// File: rtl/pinovr_rdmux.sv
module pinovr_rdmux
    import pinovr_pkg::*;
(
    input  logic              rd,
    input  logic              rmw,
    input  logic              en,
    input  logic              sin_sync,
    input  logic              sout,
    output logic [CTRL_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            rdata[EN_BIT]  = en;
            rdata[LVL_BIT] = rmw ? sout : sin_sync;
        end
    end
endmodule

// File: rtl/sout_pin_override.sv
module sout_pin_override
    import pinovr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        IDLE_LEVEL  = 1'b1,
    parameter logic        RST_LEVEL   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soe,
    input  logic              tx_data,
    input  logic              sin,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wmask,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              reg_rd,
    input  logic              reg_rmw,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              sout
);
    logic sin_sync;
    logic ovr_en;
    logic ovr_lvl;

    pinovr_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE_LEVEL)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sin),
        .dout (sin_sync)
    );

    pinovr_ctrl #(
        .IDLE_LEVEL(IDLE_LEVEL),
        .RST_LEVEL (RST_LEVEL)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .soe    (soe),
        .tx_data(tx_data),
        .wr     (reg_wr),
        .wmask  (reg_wmask),
        .wdata  (reg_wdata),
        .en     (ovr_en),
        .lvl    (ovr_lvl),
        .sout   (sout)
    );

    pinovr_rdmux u_rdmux (
        .rd      (reg_rd),
        .rmw     (reg_rmw),
        .en      (ovr_en),
        .sin_sync(sin_sync),
        .sout    (sout),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/sout_pin_override_chk.sv
module sout_pin_override_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soe,
    input logic       tx_data,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_rmw,
    input logic [1:0] reg_rdata,
    input logic       sout,
    input logic       ovr_en,
    input logic       ovr_lvl
);
    // R2
    override_drives_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soe ##1 ovr_en |-> sout == ovr_lvl);

    // R3
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soe |=> sout);

    // R4
    uart_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soe ##1 !ovr_en |-> sout == $past(tx_data));

    // R5
    bits_hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(ovr_en) && $stable(ovr_lvl)));

    // R7
    rmw_reads_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_rmw) |-> (reg_rdata[0] == sout && reg_rdata[1] == ovr_en));

    // R8
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == 2'b00);
endmodule

bind sout_pin_override sout_pin_override_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soe      (soe),
    .tx_data  (tx_data),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_rmw  (reg_rmw),
    .reg_rdata(reg_rdata),
    .sout     (sout),
    .ovr_en   (ovr_en),
    .ovr_lvl  (ovr_lvl)
);

// File: tb/tb_sout_pin_override.sv
module tb_sout_pin_override;
    logic       clk = 1'b0;
    logic       rst_n, soe, tx_data, sin, reg_wr, reg_rd, reg_rmw;
    logic [1:0] reg_wmask, reg_wdata, reg_rdata;
    logic       sout;
    int         errors = 0;
    int         checks = 0;
    bit         done   = 0;

    always #10 clk = ~clk;

    sout_pin_override dut (
        .clk(clk), .rst_n(rst_n), .soe(soe), .tx_data(tx_data), .sin(sin),
        .reg_wr(reg_wr), .reg_wmask(reg_wmask), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rmw(reg_rmw), .reg_rdata(reg_rdata), .sout(sout)
    );

    // Vector: [7] soe, [6] tx_data, [5] wr, [4:3] wmask, [2:1] wdata, [0] expected sout
    localparam logic [7:0] VEC [12] = '{
        8'b1_0_0_00_00_0,  // R4 UART data 0 passes
        8'b1_1_0_00_00_1,  // R4 UART data 1 passes
        8'b1_1_1_01_00_1,  // R5 level 0 stored, override off
        8'b1_0_0_00_00_0,  // R4 still UART data
        8'b1_1_1_10_10_0,  // R5 enable applies stored 0
        8'b1_1_0_00_00_0,  // R2 override holds 0 against tx 1
        8'b1_0_1_11_11_1,  // R2 level 1 driven
        8'b0_0_0_00_00_1,  // R3 idle high
        8'b0_0_1_01_00_1,  // R3 level 0 written, still idle
        8'b1_1_0_00_00_0,  // R2 level 0 driven again
        8'b1_0_1_10_00_0,  // R4 override off, tx 0
        8'b1_1_0_00_00_1   // R4 tx 1
    };
    localparam string VEC_REQ [12] = '{"R4", "R4", "R5", "R4", "R5", "R2",
                                       "R2", "R3", "R3", "R2", "R4", "R4"};

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; soe = 1'b0; tx_data = 1'b1; sin = 1'b1;
        reg_wr = 1'b0; reg_wmask = 2'b00; reg_wdata = 2'b00;
        reg_rd = 1'b0; reg_rmw = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        apply_reset();
        // R1 reset state
        chk("R1", {1'b0, sout}, 2'b01);
        reg_rd = 1'b1; #1;
        chk("R1", reg_rdata, 2'b01);
        reg_rmw = 1'b1; #1;
        chk("R1", reg_rdata, 2'b01);
        reg_rd = 1'b0; reg_rmw = 1'b0;

        foreach (VEC[i]) begin
            @(negedge clk);
            soe = VEC[i][7]; tx_data = VEC[i][6]; reg_wr = VEC[i][5];
            reg_wmask = VEC[i][4:3]; reg_wdata = VEC[i][2:1];
            @(negedge clk);
            reg_wr = 1'b0;
            chk(VEC_REQ[i], {1'b0, sout}, {1'b0, VEC[i][0]});
        end
        // now: soe=1, tx=1, override off, level 0, sout=1

        // R6 synchronizer latency
        sin = 1'b0; reg_rd = 1'b1; reg_rmw = 1'b0; #1;
        chk("R6", reg_rdata, 2'b01);
        @(negedge clk);
        chk("R6", reg_rdata, 2'b01);
        @(negedge clk);
        chk("R6", reg_rdata, 2'b00);

        // R7 read-modify-write read returns transmit pin (1), not receive pin (0)
        reg_rmw = 1'b1; #1;
        chk("R7", reg_rdata, 2'b01);
        reg_rd = 1'b0; reg_rmw = 1'b0;

        // R8 no read gives zero
        #1; chk("R8", reg_rdata, 2'b00);

        // R9 override on with level 0, then write back what the RMW read returns
        reg_wr = 1'b1; reg_wmask = 2'b11; reg_wdata = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9", {1'b0, sout}, 2'b00);
        sin = 1'b1;
        repeat (2) @(negedge clk);
        reg_rd = 1'b1; reg_rmw = 1'b1; #1;
        chk("R9", reg_rdata, 2'b10);
        reg_wdata = reg_rdata; reg_wmask = 2'b11; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_rmw = 1'b0;
        chk("R9", {1'b0, sout}, 2'b00);
        @(negedge clk);
        chk("R9", {1'b0, sout}, 2'b00);
        reg_rd = 1'b1; #1;
        chk("R6", reg_rdata, 2'b11);
        reg_rd = 1'b0;

        // R1 stored level resets to 1: enable alone drives 1 against tx 0
        apply_reset();
        soe = 1'b1; tx_data = 1'b0;
        reg_wr = 1'b1; reg_wmask = 2'b10; reg_wdata = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R1", {1'b0, sout}, 2'b01);

        finish_run();
    end
endmodule